// File: doc/BRIEF.md
# Hibernate Wakeup and Reset Controller

This always-on controller parks a system in a low-power hibernate state and brings it back out under control of a single wakeup pin. Software programs two coarse tick thresholds through a small register window. One sets how long the wakeup pin must be held before the system is woken. The other sets how long the system reset stays low once wakeup is granted. Software then commands hibernation. Both thresholds count periods of a slow tick enable that the surrounding always-on domain supplies. The tick source, alarm logic and power switches sit outside this block.

Each threshold keeps only a band of upper bits, so its value is a multiple of 32 ticks. Every register write is paced by a ready flag. After a write is accepted, the flag stays clear for a fixed number of ticks. Writes that arrive while the flag is clear are dropped.

Top module: `hib_wake_ctrl`

## Requirements
- R1: After reset: the wakeup threshold register (offset 0x24) reads as all of its implemented bits set, the reset-length register (offset 0x28) reads as all of its implemented bits set, bit 7 of the control register (offset 0x00) reads 1, the hibernate register (offset 0x20) reads 0, `hib_active` is 0 and `sys_rst_n` is 1.
- R2: A write accepted while control bit 7 is 1 clears that bit on the next cycle. The bit stays 0 for WRDY_TICKS ticks and then returns to 1.
- R3: A write presented while control bit 7 is 0 has no effect on any register.
- R4: The wakeup threshold keeps only bits FILT_HI..FILT_LO (default 15..5) of the written data. The reset length keeps only bits RCNT_HI..RCNT_LO (default 11..5). All other bits read as 0.
- R5: In the running state, an accepted write to offset 0x20 with bit 0 set raises `hib_active` on the next cycle. A write with bit 0 clear leaves `hib_active` at 0.
- R6: While hibernating, wakeup is granted only after `wake_pin` has stayed high across exactly the programmed number of ticks. A release of the pin restarts the count from zero.
- R7: Once wakeup is granted, `sys_rst_n` is driven low for exactly the programmed reset-length number of ticks.
- R8: When the reset pulse ends, `sys_rst_n` returns to 1 and `hib_active` returns to 0 in the same cycle.
- R9: `sys_rst_n` is low only while `hib_active` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low reset of the controller |
| tick_en | input | 1 | One-cycle pulse per slow tick period |
| wake_pin | input | 1 | Wakeup pin, active high, already synchronised |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| hib_active | output | 1 | High from hibernate entry until the reset pulse ends |
| sys_rst_n | output | 1 | Active-low system reset |

## Verification
The bench builds the block with FILT_HI = 9 and RCNT_HI = 8, so the thresholds cap at 992 and 480 ticks. At a tick every fourth clock, the full-scale settings, the zero settings and a pin glitch part-way through the count can all run to completion within a short run. WRDY_TICKS keeps its default of 2. This lets the ready window and the rejection of writes inside it be seen a few cycles after each write.

// File: rtl/hib_wake_pkg.sv
// Shared constants and types for the hibernate wakeup controller.
// Assumes byte offsets fit in the address width chosen by the top.
package hib_wake_pkg;

    localparam int unsigned OFS_CTRL      = 32'h00;
    localparam int unsigned OFS_HIB       = 32'h20;
    localparam int unsigned OFS_FILT      = 32'h24;
    localparam int unsigned OFS_RCNT      = 32'h28;
    localparam int unsigned CTRL_WRDY_BIT = 7;

    typedef enum logic [1:0] {
        ST_RUN = 2'd0,
        ST_HIB = 2'd1,
        ST_RST = 2'd2
    } hib_state_e;

endpackage

// File: rtl/hib_regs.sv
// Register window of the hibernate controller: write-ready pacing,
// the two coarse threshold fields and the hibernate command strobe.
// Assumes tick_en is a single-cycle pulse; reads are combinational.
module hib_regs
    import hib_wake_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int FILT_HI    = 15,
    parameter int FILT_LO    = 5,
    parameter int RCNT_HI    = 11,
    parameter int RCNT_LO    = 5,
    parameter int WRDY_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              hib_active,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [FILT_HI:0]  filt_thr,
    output logic [RCNT_HI:0]  rcnt_thr,
    output logic              hib_req
);

    localparam int BW = $clog2(WRDY_TICKS + 1);

    logic [FILT_HI:FILT_LO] filt_q;
    logic [RCNT_HI:RCNT_LO] rcnt_q;
    logic [BW-1:0]          busy_q;
    logic                   wrdy;
    logic                   wr_ok;
    logic                   unused_wdata;

    assign wrdy         = (busy_q == '0);
    assign wr_ok        = bus_we && wrdy;
    assign unused_wdata = ^bus_wdata;

    // Ready pacing: an accepted write blocks the window for WRDY_TICKS ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
        end else if (wr_ok) begin
            busy_q <= BW'(WRDY_TICKS);
        end else if (tick_en && (busy_q != '0)) begin
            busy_q <= busy_q - 1'b1;
        end
    end

    // Wakeup threshold field, reset to full scale.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q <= '1;
        end else if (wr_ok && (bus_addr == ADDR_W'(OFS_FILT))) begin
            filt_q <= bus_wdata[FILT_HI:FILT_LO];
        end
    end

    // Reset-length field, reset to full scale.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcnt_q <= '1;
        end else if (wr_ok && (bus_addr == ADDR_W'(OFS_RCNT))) begin
            rcnt_q <= bus_wdata[RCNT_HI:RCNT_LO];
        end
    end

    assign hib_req  = wr_ok && (bus_addr == ADDR_W'(OFS_HIB)) && bus_wdata[0];
    assign filt_thr = {filt_q, {FILT_LO{1'b0}}};
    assign rcnt_thr = {rcnt_q, {RCNT_LO{1'b0}}};

    // Read multiplexer; unimplemented bits stay zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_CTRL): bus_rdata[CTRL_WRDY_BIT]   = wrdy;
            ADDR_W'(OFS_HIB):  bus_rdata[0]               = hib_active;
            ADDR_W'(OFS_FILT): bus_rdata[FILT_HI:FILT_LO] = filt_q;
            ADDR_W'(OFS_RCNT): bus_rdata[RCNT_HI:RCNT_LO] = rcnt_q;
            default:           bus_rdata                  = '0;
        endcase
    end

    p_wrdy_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> !wrdy)
        else $error("write-ready did not drop after accepted write");

    p_ignored_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !wrdy) |=> ($stable(filt_q) && $stable(rcnt_q)))
        else $error("write while not ready changed a register");

endmodule

// File: rtl/hib_tick_count.sv
// Tick counter that qualifies a condition over a programmed number of
// slow ticks. It clears whenever the region is left or the condition drops.
// Assumes thr is stable while counting; done is combinational.
module hib_tick_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         hold,
    input  logic         tick_en,
    input  logic [W-1:0] thr,
    output logic         done
);

    logic [W-1:0] cnt_q;

    // Count ticks while the condition holds; restart on any break.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || !hold) begin
            cnt_q <= '0;
        end else if (tick_en && (cnt_q < thr)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && hold && (cnt_q >= thr);

    p_restart_on_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run || !hold) |=> (cnt_q == '0))
        else $error("tick count did not restart");

endmodule

// File: rtl/hib_wake_ctrl.sv
// Top of the hibernate wakeup and reset controller. It sequences
// running -> hibernate -> reset pulse -> running. Assumes wake_pin is
// synchronised to clk and tick_en pulses one cycle per slow tick.
module hib_wake_ctrl
    import hib_wake_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int FILT_HI    = 15,
    parameter int FILT_LO    = 5,
    parameter int RCNT_HI    = 11,
    parameter int RCNT_LO    = 5,
    parameter int WRDY_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wake_pin,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              hib_active,
    output logic              sys_rst_n
);

    hib_state_e        st_q;
    hib_state_e        st_d;
    logic [FILT_HI:0]  filt_thr;
    logic [RCNT_HI:0]  rcnt_thr;
    logic              hib_req;
    logic              wake_done;
    logic              pulse_done;

    hib_regs #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .FILT_HI   (FILT_HI),
        .FILT_LO   (FILT_LO),
        .RCNT_HI   (RCNT_HI),
        .RCNT_LO   (RCNT_LO),
        .WRDY_TICKS(WRDY_TICKS)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .hib_active(hib_active),
        .bus_rdata (bus_rdata),
        .filt_thr  (filt_thr),
        .rcnt_thr  (rcnt_thr),
        .hib_req   (hib_req)
    );

    hib_tick_count #(.W(FILT_HI + 1)) i_wake_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (st_q == ST_HIB),
        .hold   (wake_pin),
        .tick_en(tick_en),
        .thr    (filt_thr),
        .done   (wake_done)
    );

    hib_tick_count #(.W(RCNT_HI + 1)) i_rst_len (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (st_q == ST_RST),
        .hold   (1'b1),
        .tick_en(tick_en),
        .thr    (rcnt_thr),
        .done   (pulse_done)
    );

    // Next-state selection for the hibernate sequence.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_RUN:  if (hib_req)    st_d = ST_HIB;
            ST_HIB:  if (wake_done)  st_d = ST_RST;
            ST_RST:  if (pulse_done) st_d = ST_RUN;
            default: st_d = ST_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    assign hib_active = (st_q != ST_RUN);
    assign sys_rst_n  = (st_q != ST_RST);

    p_enter_hib_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hib_active && hib_req) |=> hib_active)
        else $error("hibernate command not taken");

    p_wake_needs_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sys_rst_n) && $past(hib_active)) |-> $past(wake_pin))
        else $error("wakeup without pin");

    p_pulse_ends_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> !hib_active)
        else $error("reset pulse end did not return to running");

    p_rst_in_hib_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_rst_n |-> hib_active)
        else $error("system reset outside hibernate sequence");

endmodule

// File: tb/test_hib_wake_ctrl.sv
// Scoreboard bench: the driver queues expected filter and reset tick
// counts per hibernate cycle; a monitor measures and compares them.
module test_hib_wake_ctrl;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int FILT_HI = 9;
    localparam int FILT_LO = 5;
    localparam int RCNT_HI = 8;
    localparam int RCNT_LO = 5;
    localparam int FMASK   = ((1 << (FILT_HI + 1)) - 1) & ~((1 << FILT_LO) - 1);
    localparam int RMASK   = ((1 << (RCNT_HI + 1)) - 1) & ~((1 << RCNT_LO) - 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_en = 1'b0;
    logic              wake_pin = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              hib_active;
    logic              sys_rst_n;

    int checks = 0;
    int errors = 0;
    int exp_filt_q[$];
    int exp_rcnt_q[$];

    hib_wake_ctrl #(
        .ADDR_W (ADDR_W),  .DATA_W (DATA_W),
        .FILT_HI(FILT_HI), .FILT_LO(FILT_LO),
        .RCNT_HI(RCNT_HI), .RCNT_LO(RCNT_LO),
        .WRDY_TICKS(2)
    ) i_hib_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wake_pin(wake_pin),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .hib_active(hib_active), .sys_rst_n(sys_rst_n)
    );

    always #2 clk = ~clk;

    // Tick every fourth cycle.
    int tdiv = 0;
    always @(posedge clk) begin
        #1;
        tdiv = (tdiv + 1) % 4;
        tick_en = (tdiv == 0);
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input int addr, output logic [DATA_W-1:0] data);
        @(posedge clk); #1 bus_addr = ADDR_W'(addr);
        @(negedge clk); data = bus_rdata;
    endtask

    task automatic wr(input int addr, input logic [DATA_W-1:0] data);
        @(posedge clk); #1;
        bus_addr = ADDR_W'(addr); bus_wdata = data; bus_we = 1'b1;
        @(posedge clk); #1 bus_we = 1'b0;
    endtask

    task automatic wait_ready();
        logic [DATA_W-1:0] d;
        do rd(32'h00, d); while (!d[7]);
    endtask

    task automatic sync_tick();
        do @(negedge clk); while (!tick_en);
        @(posedge clk); #1;
    endtask

    // Driver: program, hibernate, wake; pushes the expected tick counts.
    task automatic do_hibernate(input int filt, input int rcnt, input bit glitch);
        wait_ready(); wr(32'h24, DATA_W'(filt));
        wait_ready(); wr(32'h28, DATA_W'(rcnt));
        wait_ready(); wr(32'h20, 32'h1);
        @(negedge clk);
        check("R5 hibernate entered", hib_active, 1);
        exp_filt_q.push_back(filt & FMASK);
        exp_rcnt_q.push_back(rcnt & RMASK);
        if (glitch) begin
            sync_tick(); wake_pin = 1'b1;
            repeat (12) @(posedge clk);
            #1 wake_pin = 1'b0;
            repeat (8) @(negedge clk);
            check("R6 short assertion keeps hibernate", hib_active, 1);
            check("R6 short assertion keeps reset high", sys_rst_n, 1);
        end
        sync_tick(); wake_pin = 1'b1;
        do @(negedge clk); while (hib_active);
        @(posedge clk); #1 wake_pin = 1'b0;
    endtask

    // Monitor: measures pin-qualified ticks and reset-low ticks.
    int  run_ticks = 0;
    int  filt_seen = 0;
    int  rticks    = 0;
    bit  prev_srst = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!sys_rst_n) begin
                if (prev_srst) begin
                    filt_seen = run_ticks;
                    rticks    = 0;
                end
                if (tick_en) rticks++;
            end else begin
                if (!prev_srst) begin
                    if (exp_filt_q.size() == 0) begin
                        check("R6 unexpected wakeup", 1, 0);
                    end else begin
                        check("R6 wake filter ticks", filt_seen, exp_filt_q.pop_front());
                        check("R7 reset low ticks", rticks, exp_rcnt_q.pop_front());
                        check("R8 status cleared after pulse", hib_active, 0);
                    end
                end
                if (hib_active && wake_pin) begin
                    if (tick_en) run_ticks++;
                end else begin
                    run_ticks = 0;
                end
            end
            prev_srst = sys_rst_n;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] d;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check("R1 sys_rst_n", sys_rst_n, 1);
        check("R1 hib_active", hib_active, 0);
        rd(32'h00, d); check("R1 ctrl ready bit", d, 32'h80);
        rd(32'h20, d); check("R1 hibernate reg", d, 0);
        rd(32'h24, d); check("R1 filter full scale", d, FMASK);
        rd(32'h28, d); check("R1 reset length full scale", d, RMASK);

        // R4 unimplemented bits
        wr(32'h24, 32'hFFFF_FFFF);
        wait_ready(); rd(32'h24, d); check("R4 filter keeps field only", d, FMASK);
        wr(32'h28, 32'h0000_001F);
        wait_ready(); rd(32'h28, d); check("R4 reset length low bits dropped", d, 0);

        // R2 ready window
        wr(32'h28, 32'h40);
        rd(32'h00, d); check("R2 ready clear after write", d[7], 0);
        repeat (12) @(posedge clk);
        rd(32'h00, d); check("R2 ready back after ticks", d[7], 1);

        // R3 write while not ready is dropped
        wr(32'h24, 32'h140);
        wr(32'h24, 32'h2A0);
        wait_ready(); rd(32'h24, d); check("R3 ignored write", d, 32'h140);

        // R5 write of 0 does not hibernate
        wr(32'h20, 32'h0);
        @(negedge clk); check("R5 zero write no hibernate", hib_active, 0);

        // R6/R7/R8 hibernate cycles
        do_hibernate(64, 32, 1'b0);
        do_hibernate(100, 32'h47, 1'b1);
        do_hibernate(0, 0, 1'b0);
        do_hibernate(32'hFFFF, 32'hFFFF, 1'b0);
        repeat (4) @(negedge clk);
        check("R8 all wakeups observed", exp_filt_q.size(), 0);
        check("R9 reset high at end", sys_rst_n, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule